// File: doc/BRIEF.md
# Pipe Buffer Access Status Tracker

This block follows how full the buffer of a single pipe is, where that buffer may be split into two halves used in alternation. It keeps one occupancy bit for each half. It also keeps two rotating pointers. The first pointer marks the half that belongs to the processor or DMA side. The second marks the half that belongs to the bus side. Completion strobes from both sides update the occupancy bits, and each pointer moves to the other half when its own side finishes with a half. The pointers move only when double buffering is enabled. With it disabled, half 0 is the only one used.

From this state the block produces two flags. The access flag tells the processor whether it may touch the buffer now. In receive direction it means there is data to read. In transmit direction it means there is room to write. The monitor flag shows whether any transmit data is still waiting. In receive direction it copies the access flag.

A buffer-ready mode changes how a completed read is handled. In that mode the flag stays high after the read until software issues an explicit clear. Setting combinations that have no defined meaning raise an error output, and the block then forces both flags low.

Top module: `pipeBufStatus`

## Requirements
- R1: After reset, no half is occupied and both pointers select half 0. In receive direction the access flag and the monitor flag are both 0. In transmit direction (dirTx=1) the access flag is 1 and the monitor flag is 0.
- R2: In receive direction with buffer-ready mode off, a received-half strobe raises the access flag on the next clock. A read-complete strobe on the processor's half lowers it on the next clock if no other half holds data.
- R3: In receive direction with buffer-ready mode on and auto-clear mode off, a read-complete strobe leaves the access flag high. A software clear strobe then empties the processor's half, and the flag falls on the next clock.
- R4: In transmit direction with a single half, a write-complete strobe lowers the access flag and raises the monitor flag on the next clock. A transmitted strobe restores access to 1 and monitor to 0 on the next clock.
- R5: In transmit direction with double buffering, the first write-complete strobe leaves access at 1, and the second lowers it. The monitor flag stays 1 until both halves have been transmitted, and then it reads 0.
- R6: In receive direction with double buffering, two halves can be received in turn. After the first half is read, the access flag stays 1 because the second half is still full. After the second half is read, the flag falls.
- R7: In receive direction with legal settings, the monitor flag always equals the access flag.
- R8: The illegal settings are transmit with buffer-ready mode or auto-clear mode on, and receive with both of those modes on. Under these settings modeErr is 1 and both flags are 0. All other settings give modeErr=0.
- R9: With double buffering off, a received-half strobe that arrives while half 0 is full is ignored. One read-complete strobe then empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirTx | input | 1 | 1 = transmit, 0 = receive |
| dblBuf | input | 1 | Use two halves in alternation |
| bufReadyMode | input | 1 | Hold access after a read until a software clear |
| autoClrMode | input | 1 | Auto-clear mode setting (only affects legality here) |
| cpuWrDone | input | 1 | Processor/DMA finished writing its half |
| cpuRdDone | input | 1 | Processor/DMA finished reading its half |
| usbTxDone | input | 1 | Bus side finished sending its half |
| usbRxDone | input | 1 | Bus side finished filling its half |
| swClear | input | 1 | Software buffer clear of the processor's half |
| accessOk | output | 1 | Processor/DMA may access the buffer |
| txBufMon | output | 1 | Transmit data still pending (receive: copy of accessOk) |
| modeErr | output | 1 | Illegal setting combination |

## Verification
Every strobe updates the occupancy registers at the clock edge where it is sampled. Both flags are decoded combinationally from those registers, so each result appears one clock after its stimulus. The modeErr output and the forced-low flags follow the setting inputs with no delay at all. The bench drives each strobe for exactly one cycle, launched on a falling edge. It reads the outputs on the falling edge that follows the capturing rising edge, which is the first point where the new value is due and where it is stable. Setting inputs change only while reset is held, so the outputs never depend on a change of settings in the middle of a scenario.

// File: rtl/pipeBufStatusPkg.sv
package pipeBufStatusPkg;
  localparam int SIDES = 2;
  localparam int PTR_W = (SIDES > 1) ? $clog2(SIDES) : 1;

  typedef struct packed {
    logic cpuSet;
    logic cpuClr;
    logic cpuAdv;
    logic usbSet;
    logic usbClr;
    logic usbAdv;
  } sideStrobes_t;
endpackage

// File: rtl/pipeBufCtl.sv
module pipeBufCtl
  import pipeBufStatusPkg::*;
(
  input  logic         dirTx,
  input  logic         dblBuf,
  input  logic         bufReadyMode,
  input  logic         autoClrMode,
  input  logic         cpuWrDone,
  input  logic         cpuRdDone,
  input  logic         usbTxDone,
  input  logic         usbRxDone,
  input  logic         swClear,
  input  logic         cpuSideFull,
  input  logic         usbSideFull,
  input  logic         anyFull,
  output sideStrobes_t strobes,
  output logic         accessOk,
  output logic         txBufMon,
  output logic         modeErr
);
  logic legal;
  logic holdAfterRead;

  always_comb begin
    legal = dirTx ? (!bufReadyMode && !autoClrMode) : !(bufReadyMode && autoClrMode);
    holdAfterRead = !dirTx && bufReadyMode;
    strobes = '0;
    if (dirTx) begin
      strobes.cpuSet = cpuWrDone && !cpuSideFull;
      strobes.cpuAdv = strobes.cpuSet && dblBuf;
      strobes.cpuClr = swClear;
      strobes.usbClr = usbTxDone && usbSideFull;
      strobes.usbAdv = strobes.usbClr && dblBuf;
    end else begin
      strobes.usbSet = usbRxDone && !usbSideFull;
      strobes.usbAdv = strobes.usbSet && dblBuf;
      strobes.cpuClr = (swClear || (cpuRdDone && !holdAfterRead)) && cpuSideFull;
      strobes.cpuAdv = strobes.cpuClr && dblBuf;
    end
  end

  assign modeErr  = !legal;
  assign accessOk = legal && (dirTx ? !cpuSideFull : cpuSideFull);
  assign txBufMon = legal && (dirTx ? anyFull : cpuSideFull);
endmodule

// File: rtl/pipeBufData.sv
module pipeBufData
  import pipeBufStatusPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  sideStrobes_t strobes,
  output logic         cpuSideFull,
  output logic         usbSideFull,
  output logic         anyFull
);
  logic [PTR_W-1:0] cpuPtr;
  logic [PTR_W-1:0] usbPtr;
  logic [SIDES-1:0] sideFull;

  function automatic logic [PTR_W-1:0] nextSide(input logic [PTR_W-1:0] p);
    nextSide = (int'(p) == SIDES - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuPtr <= '0;
      usbPtr <= '0;
    end else begin
      if (strobes.cpuAdv) cpuPtr <= nextSide(cpuPtr);
      if (strobes.usbAdv) usbPtr <= nextSide(usbPtr);
    end
  end

  for (genvar s = 0; s < SIDES; s++) begin : gSide
    logic setHere;
    logic clrHere;
    assign setHere = (strobes.cpuSet && int'(cpuPtr) == s) || (strobes.usbSet && int'(usbPtr) == s);
    assign clrHere = (strobes.cpuClr && int'(cpuPtr) == s) || (strobes.usbClr && int'(usbPtr) == s);
    always_ff @(posedge clk) begin
      if (!rstN) sideFull[s] <= 1'b0;
      else if (setHere) sideFull[s] <= 1'b1;
      else if (clrHere) sideFull[s] <= 1'b0;
    end
  end

  assign cpuSideFull = sideFull[cpuPtr];
  assign usbSideFull = sideFull[usbPtr];
  assign anyFull     = |sideFull;
endmodule

// File: rtl/pipeBufStatus.sv
module pipeBufStatus
  import pipeBufStatusPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic dirTx,
  input  logic dblBuf,
  input  logic bufReadyMode,
  input  logic autoClrMode,
  input  logic cpuWrDone,
  input  logic cpuRdDone,
  input  logic usbTxDone,
  input  logic usbRxDone,
  input  logic swClear,
  output logic accessOk,
  output logic txBufMon,
  output logic modeErr
);
  sideStrobes_t strobes;
  logic cpuSideFull;
  logic usbSideFull;
  logic anyFull;

  pipeBufCtl uCtl (
    .dirTx(dirTx), .dblBuf(dblBuf), .bufReadyMode(bufReadyMode), .autoClrMode(autoClrMode),
    .cpuWrDone(cpuWrDone), .cpuRdDone(cpuRdDone), .usbTxDone(usbTxDone), .usbRxDone(usbRxDone),
    .swClear(swClear), .cpuSideFull(cpuSideFull), .usbSideFull(usbSideFull), .anyFull(anyFull),
    .strobes(strobes), .accessOk(accessOk), .txBufMon(txBufMon), .modeErr(modeErr)
  );

  pipeBufData uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cpuSideFull(cpuSideFull), .usbSideFull(usbSideFull), .anyFull(anyFull)
  );
endmodule

// File: rtl/pipeBufStatusChk.sv
module pipeBufStatusChk (
  input logic clk,
  input logic rstN,
  input logic dirTx,
  input logic dblBuf,
  input logic bufReadyMode,
  input logic autoClrMode,
  input logic cpuWrDone,
  input logic cpuRdDone,
  input logic usbTxDone,
  input logic usbRxDone,
  input logic swClear,
  input logic accessOk,
  input logic txBufMon,
  input logic modeErr
);
  logic legalRx;
  logic legalTx;
  logic cfgSame;
  assign legalRx = !dirTx && !(bufReadyMode && autoClrMode);
  assign legalTx = dirTx && !bufReadyMode && !autoClrMode;

  logic [3:0] cfgPrev;
  always_ff @(posedge clk) cfgPrev <= {dirTx, dblBuf, bufReadyMode, autoClrMode};
  assign cfgSame = (cfgPrev == {dirTx, dblBuf, bufReadyMode, autoClrMode});

  // R8
  illegal_flags_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> (!accessOk && !txBufMon));

  // R7
  rx_monitor_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    legalRx |-> (txBufMon == accessOk));

  // R3
  ready_mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (legalRx && bufReadyMode && accessOk && !swClear) |=> (accessOk || !cfgSame));

  // R4
  tx_single_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (legalTx && !dblBuf && accessOk && cpuWrDone && !swClear) |=> (!accessOk || !cfgSame));

  // R2
  rx_single_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (legalRx && !bufReadyMode && !dblBuf && accessOk && cpuRdDone) |=> (!accessOk || !cfgSame));
endmodule

bind pipeBufStatus pipeBufStatusChk uChk (
  .clk(clk), .rstN(rstN), .dirTx(dirTx), .dblBuf(dblBuf), .bufReadyMode(bufReadyMode),
  .autoClrMode(autoClrMode), .cpuWrDone(cpuWrDone), .cpuRdDone(cpuRdDone),
  .usbTxDone(usbTxDone), .usbRxDone(usbRxDone), .swClear(swClear),
  .accessOk(accessOk), .txBufMon(txBufMon), .modeErr(modeErr)
);

// File: tb/tb_pipeBufStatus.sv
module tb_pipeBufStatus;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirTx = 1'b0, dblBuf = 1'b0, bufReadyMode = 1'b0, autoClrMode = 1'b0;
  logic cpuWrDone = 1'b0, cpuRdDone = 1'b0, usbTxDone = 1'b0, usbRxDone = 1'b0, swClear = 1'b0;
  logic accessOk, txBufMon, modeErr;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipeBufStatus dut (.*);

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {access,mon,err} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic expectFlags(input string req, input logic a, input logic m, input logic e);
    check(req, {accessOk, txBufMon, modeErr}, {a, m, e});
  endtask

  task automatic startCfg(input logic tx, input logic dbl, input logic rdy, input logic acl);
    @(negedge clk);
    rstN = 1'b0;
    dirTx = tx; dblBuf = dbl; bufReadyMode = rdy; autoClrMode = acl;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // 0=cpuWr 1=cpuRd 2=usbTx 3=usbRx 4=swClear; result sampled one clock later
  task automatic pulse(input int which);
    case (which)
      0: cpuWrDone = 1'b1;
      1: cpuRdDone = 1'b1;
      2: usbTxDone = 1'b1;
      3: usbRxDone = 1'b1;
      default: swClear = 1'b1;
    endcase
    @(negedge clk);
    {cpuWrDone, cpuRdDone, usbTxDone, usbRxDone, swClear} = '0;
  endtask

  task automatic testRxSingle();
    startCfg(1'b0, 1'b0, 1'b0, 1'b0);
    expectFlags("R1 rx reset", 1'b0, 1'b0, 1'b0);
    pulse(3);
    expectFlags("R2 rx data ready / R7", 1'b1, 1'b1, 1'b0);
    pulse(3);
    expectFlags("R9 extra receive ignored", 1'b1, 1'b1, 1'b0);
    pulse(1);
    expectFlags("R2 read drains / R9 single half", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testRxReady();
    startCfg(1'b0, 1'b0, 1'b1, 1'b0);
    expectFlags("R8 rx ready mode legal", 1'b0, 1'b0, 1'b0);
    pulse(3);
    expectFlags("R3 ready mode data", 1'b1, 1'b1, 1'b0);
    pulse(1);
    expectFlags("R3 hold after read", 1'b1, 1'b1, 1'b0);
    pulse(4);
    expectFlags("R3 software clear", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testTxSingle();
    startCfg(1'b1, 1'b0, 1'b0, 1'b0);
    expectFlags("R1 tx reset", 1'b1, 1'b0, 1'b0);
    pulse(0);
    expectFlags("R4 write fills", 1'b0, 1'b1, 1'b0);
    pulse(2);
    expectFlags("R4 transmit empties", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testTxDouble();
    startCfg(1'b1, 1'b1, 1'b0, 1'b0);
    pulse(0);
    expectFlags("R5 first half written", 1'b1, 1'b1, 1'b0);
    pulse(0);
    expectFlags("R5 both halves written", 1'b0, 1'b1, 1'b0);
    pulse(2);
    expectFlags("R5 one half sent", 1'b1, 1'b1, 1'b0);
    pulse(2);
    expectFlags("R5 both halves sent", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testRxDouble();
    startCfg(1'b0, 1'b1, 1'b0, 1'b0);
    pulse(3);
    pulse(3);
    expectFlags("R6 two halves received", 1'b1, 1'b1, 1'b0);
    pulse(1);
    expectFlags("R6 second half pending", 1'b1, 1'b1, 1'b0);
    pulse(1);
    expectFlags("R6 all read", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testIllegal();
    startCfg(1'b1, 1'b0, 1'b1, 1'b0);
    expectFlags("R8 tx ready mode illegal", 1'b0, 1'b0, 1'b1);
    startCfg(1'b1, 1'b0, 1'b0, 1'b1);
    expectFlags("R8 tx auto-clear illegal", 1'b0, 1'b0, 1'b1);
    startCfg(1'b0, 1'b0, 1'b1, 1'b1);
    pulse(3);
    expectFlags("R8 rx both modes illegal", 1'b0, 1'b0, 1'b1);
    startCfg(1'b0, 1'b0, 1'b0, 1'b1);
    pulse(3);
    expectFlags("R8 rx auto-clear legal / R7", 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    fork
      begin
        testRxSingle();
        testRxReady();
        testTxSingle();
        testTxDouble();
        testRxDouble();
        testIllegal();
        finished = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
          checks++;
          errors++;
          $display("FAIL watchdog: actual=timeout expected=done");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule